// File: doc/BRIEF.md
# Burst Hit Derandomizing Buffer

This block sits between a detector front end that produces one hit strobe per sampling interval and a slower histogram update path. Each accepted hit is tagged with the cycle-relative sample index present on the time input at that sampling edge. The tag is pushed into a first-in first-out queue, and the queue is presented to the drain side as a valid/ready stream. Hits can arrive on every sample clock during a burst. The drain side can then empty the queue at its own pace.

A window-enable qualifier gates acceptance, so hits that fall in the suppress or dead parts of an acquisition cycle never reach the queue. The queue is deep enough to hold the worst-case burst: 16 hits in each of 64 consecutive 16-sample frames, drained at one entry per 16 clocks. A hit that finds the queue full is dropped. That drop raises a sticky overflow flag, which only a reset clears, so the loss is never silent.

Top module: `hit_derand_buffer`

## Requirements
- R1: After reset, `ts_valid_o` and `overflow_o` are both 0.
- R2: At a rising clock edge where `hit_i` and `window_i` are both 1 and the queue has room, the value of `time_i` is stored. If the queue was empty, `ts_valid_o` is 1 from that edge on, with `ts_data_o` equal to the stored value.
- R3: A hit strobe while `window_i` is 0 is ignored: it adds no entry and does not change `overflow_o`.
- R4: Entries leave in arrival order. Hits on consecutive clocks are all accepted. An entry is removed at an edge where `ts_valid_o` and `ts_ready_i` are both 1.
- R5: While `ts_valid_o` is 1 and `ts_ready_i` is 0, `ts_valid_o` stays 1 and `ts_data_o` holds its value.
- R6: The queue holds DEPTH entries (default 1024). Accepting DEPTH hits with no removal leaves `overflow_o` at 0.
- R7: A qualified hit at an edge where the queue holds DEPTH entries and no entry is removed is discarded, and `overflow_o` becomes 1. The stored entries are unchanged.
- R8: Once `overflow_o` is 1, it stays 1 until `rst_ni` is asserted (active low).
- R9: When the queue is full and an entry is removed at the same edge as a qualified hit, the hit is accepted and `overflow_o` stays 0.
- R10: The following burst loses no hit and does not set `overflow_o`: 64 frames of 16 sample clocks, a hit on every clock, and one removal per 16 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | 1 | Hit strobe for this sampling interval |
| time_i | input | TW | Cycle-relative sample index |
| window_i | input | 1 | Acceptance window qualifier |
| ts_valid_o | output | 1 | Queue head is valid |
| ts_data_o | output | TW | Time stamp at the queue head |
| ts_ready_i | input | 1 | Drain side accepts the head |
| overflow_o | output | 1 | Sticky flag: a hit was lost |

## Verification
On every cycle, the assertions check the following:
- the head is held while the drain side stalls;
- the overflow flag stays set once it is set;
- the flag is raised by a drop at full;
- the flag stays clear when a removal frees room;
- the fill level changes only with a push or a removal;
- the fill level never exceeds the depth.

Only the bench's scenarios can show the properties that need end-to-end tracking:
- entries come out in arrival order with the correct tags;
- a dropped hit leaves the stored contents intact;
- the full 64-frame burst envelope passes with no hit lost.

// File: rtl/hdb_pkg.sv
`timescale 1ns/1ps
package hdb_pkg;
    localparam int unsigned HDB_DEF_DEPTH = 1024;
    localparam int unsigned HDB_DEF_TW    = 15;

    function automatic bit hdb_is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction
endpackage

// File: rtl/hdb_gate.sv
`timescale 1ns/1ps
module hdb_gate #(
    parameter int unsigned TW = 15
) (
    input  logic          hit_i,
    input  logic          window_i,
    input  logic [TW-1:0] time_i,
    output logic          push_req_o,
    output logic [TW-1:0] stamp_o
);
    // A hit counts only inside the acceptance window.
    always_comb begin
        push_req_o = hit_i & window_i;
        stamp_o    = time_i;
    end
endmodule

// File: rtl/hdb_store.sv
`timescale 1ns/1ps
module hdb_store #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned TW    = 15,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [TW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [TW-1:0] rdata_o
);
    logic [TW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    // Show-ahead read: the head entry is visible without a request.
    always_comb begin
        rdata_o = mem_q[raddr_i];
    end
endmodule

// File: rtl/hdb_ctrl.sv
`timescale 1ns/1ps
module hdb_ctrl #(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          push_req_i,
    input  logic          ready_i,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [AW-1:0] raddr_o,
    output logic          valid_o,
    output logic          overflow_o,
    output logic [CW-1:0] level_o
);
    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] level;
        logic          ovf;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic pop_w, room_w, push_w, drop_w;

    always_comb begin
        st_d   = st_q;
        pop_w  = (st_q.level != '0) && ready_i;
        // A removal at the same edge frees a slot for the incoming hit.
        room_w = (st_q.level != CW'(DEPTH)) || pop_w;
        push_w = push_req_i && room_w;
        drop_w = push_req_i && !room_w;
        if (push_w) begin
            st_d.wr_ptr = st_q.wr_ptr + AW'(1);
        end
        if (pop_w) begin
            st_d.rd_ptr = st_q.rd_ptr + AW'(1);
        end
        st_d.level = st_q.level + CW'(push_w) - CW'(pop_w);
        st_d.ovf   = st_q.ovf | drop_w;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        we_o       = push_w;
        waddr_o    = st_q.wr_ptr;
        raddr_o    = st_q.rd_ptr;
        valid_o    = (st_q.level != '0);
        overflow_o = st_q.ovf;
        level_o    = st_q.level;
    end
endmodule

// File: rtl/hit_derand_buffer.sv
`timescale 1ns/1ps
module hit_derand_buffer #(
    parameter int unsigned DEPTH = hdb_pkg::HDB_DEF_DEPTH,
    parameter int unsigned TW    = hdb_pkg::HDB_DEF_TW
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          hit_i,
    input  logic [TW-1:0] time_i,
    input  logic          window_i,
    output logic          ts_valid_o,
    output logic [TW-1:0] ts_data_o,
    input  logic          ts_ready_i,
    output logic          overflow_o
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    initial begin
        if (!hdb_pkg::hdb_is_pow2(DEPTH)) begin
            $error("DEPTH must be a power of two");
        end
    end

    logic          push_req_w;
    logic [TW-1:0] stamp_w;
    logic          we_w;
    logic [AW-1:0] waddr_w, raddr_w;
    logic [CW-1:0] level_w;

    hdb_gate #(.TW(TW)) gate_i (
        .hit_i      (hit_i),
        .window_i   (window_i),
        .time_i     (time_i),
        .push_req_o (push_req_w),
        .stamp_o    (stamp_w)
    );

    hdb_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .push_req_i (push_req_w),
        .ready_i    (ts_ready_i),
        .we_o       (we_w),
        .waddr_o    (waddr_w),
        .raddr_o    (raddr_w),
        .valid_o    (ts_valid_o),
        .overflow_o (overflow_o),
        .level_o    (level_w)
    );

    hdb_store #(.DEPTH(DEPTH), .TW(TW)) store_i (
        .clk_i   (clk_i),
        .we_i    (we_w),
        .waddr_i (waddr_w),
        .wdata_i (stamp_w),
        .raddr_i (raddr_w),
        .rdata_o (ts_data_o)
    );
endmodule

// File: rtl/hdb_checker.sv
`timescale 1ns/1ps
module hdb_checker #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned TW    = 15,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          hit_i,
    input logic          window_i,
    input logic          ts_ready_i,
    input logic          ts_valid_o,
    input logic [TW-1:0] ts_data_o,
    input logic          overflow_o,
    input logic [CW-1:0] level_w
);
    logic full_w, pop_w, qual_w;
    assign full_w = (level_w == CW'(DEPTH));
    assign pop_w  = ts_valid_o && ts_ready_i;
    assign qual_w = hit_i && window_i;

    assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ts_valid_o && !ts_ready_i) |=> (ts_valid_o && $stable(ts_data_o)));

    assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overflow_o |=> overflow_o);

    assert_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_w && qual_w && !pop_w) |=> overflow_o);

    assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_w && qual_w && pop_w && !overflow_o) |=> !overflow_o);

    assert_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!qual_w && !pop_w) |=> ($stable(level_w) && $stable(overflow_o)));

    assert_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        level_w <= CW'(DEPTH));
endmodule

bind hit_derand_buffer hdb_checker #(.DEPTH(DEPTH), .TW(TW)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit_i),
    .window_i   (window_i),
    .ts_ready_i (ts_ready_i),
    .ts_valid_o (ts_valid_o),
    .ts_data_o  (ts_data_o),
    .overflow_o (overflow_o),
    .level_w    (level_w)
);

// File: tb/hit_derand_buffer_tb_top.sv
`timescale 1ns/1ps
module hit_derand_buffer_tb_top;
    localparam int DEPTH = 1024;
    localparam int TW    = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hit = 1'b0;
    logic [TW-1:0] tim = '0;
    logic          win = 1'b0;
    logic          rdy = 1'b0;
    logic          vld;
    logic [TW-1:0] dat;
    logic          ovf;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hit_derand_buffer #(.DEPTH(DEPTH), .TW(TW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .hit_i(hit), .time_i(tim),
        .window_i(win), .ts_valid_o(vld), .ts_data_o(dat),
        .ts_ready_i(rdy), .overflow_o(ovf)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        hit = 0; win = 0; rdy = 0; rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    // Drain n entries, checking they equal base, base+step, ...
    task automatic drain_seq(input int n, input int base, input int step, input string req);
        int errs = 0;
        rdy = 1;
        for (int i = 0; i < n; i++) begin
            if (!vld || dat != TW'(base + i * step)) begin
                if (errs == 0) chk(0, req, "drain data", int'(dat), (base + i * step) % 32768);
                errs++;
            end
            @(negedge clk);
        end
        rdy = 0;
        if (errs == 0) chk(1, req, "drain data", 0, 0);
    endtask

    task automatic fill(input int n, input int base);
        win = 1;
        for (int i = 0; i < n; i++) begin
            hit = 1; tim = TW'(base + i);
            @(negedge clk);
        end
        hit = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(vld == 0, "R1", "valid after reset", vld, 0);
        chk(ovf == 0, "R1", "overflow after reset", ovf, 0);
    endtask

    task automatic t_single();
        do_reset();
        rdy = 1; @(negedge clk); rdy = 0;   // ready while empty: no effect
        win = 1; hit = 1; tim = 15'd5;
        @(negedge clk);
        hit = 0; tim = 15'd99;
        chk(vld == 1, "R2", "valid after one hit", vld, 1);
        chk(dat == 15'd5, "R2", "stamp", dat, 5);
        drain_seq(1, 5, 0, "R2");
        chk(vld == 0, "R2", "empty after drain", vld, 0);
    endtask

    task automatic t_window();
        do_reset();
        win = 0;
        for (int i = 0; i < 10; i++) begin
            hit = 1; tim = TW'(i);
            @(negedge clk);
        end
        hit = 0;
        chk(vld == 0, "R3", "no entry outside window", vld, 0);
        chk(ovf == 0, "R3", "overflow outside window", ovf, 0);
    endtask

    task automatic t_order();
        do_reset();
        win = 1;
        for (int i = 0; i < 20; i++) begin
            hit = 1; tim = TW'(100 + 3 * i);
            @(negedge clk);
        end
        hit = 0;
        repeat (4) @(negedge clk);
        chk(vld == 1 && dat == 15'd100, "R5", "head held under stall", dat, 100);
        drain_seq(20, 100, 3, "R4");
        chk(vld == 0, "R4", "empty after order drain", vld, 0);
    endtask

    task automatic t_full();
        do_reset();
        fill(DEPTH, 0);
        chk(ovf == 0, "R6", "overflow at exactly full", ovf, 0);
        win = 1; hit = 1; tim = 15'd7777;
        @(negedge clk);
        hit = 0;
        chk(ovf == 1, "R7", "overflow on drop", ovf, 1);
        drain_seq(DEPTH, 0, 1, "R7");
        chk(vld == 0, "R7", "dropped hit not stored", vld, 0);
        repeat (5) @(negedge clk);
        chk(ovf == 1, "R8", "overflow sticky", ovf, 1);
        do_reset();
        chk(ovf == 0, "R8", "overflow cleared by reset", ovf, 0);
    endtask

    task automatic t_full_pop();
        do_reset();
        fill(DEPTH, 0);
        win = 1; hit = 1; tim = TW'(DEPTH); rdy = 1;
        @(negedge clk);
        hit = 0; rdy = 0;
        chk(ovf == 0, "R9", "no overflow with simultaneous pop", ovf, 0);
        drain_seq(DEPTH, 1, 1, "R9");
        chk(vld == 0, "R9", "empty after drain", vld, 0);
    endtask

    task automatic t_burst();
        int exp_q [$];
        int got = 0;
        int errs = 0;
        do_reset();
        win = 1;
        for (int c = 0; c < 64 * 16; c++) begin
            hit = 1; tim = TW'(c);
            rdy = ((c % 16) == 15) && vld;
            if (rdy) begin
                if (exp_q.size() == 0 || int'(dat) != exp_q[0]) errs++;
                if (exp_q.size() != 0) void'(exp_q.pop_front());
                got++;
            end
            exp_q.push_back(c);
            @(negedge clk);
        end
        hit = 0; rdy = 1;
        while (vld) begin
            if (exp_q.size() == 0 || int'(dat) != exp_q[0]) errs++;
            if (exp_q.size() != 0) void'(exp_q.pop_front());
            got++;
            @(negedge clk);
        end
        rdy = 0;
        chk(ovf == 0, "R10", "burst overflow", ovf, 0);
        chk(got == 1024, "R10", "burst entries out", got, 1024);
        chk(errs == 0, "R10", "burst order mismatches", errs, 0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_window();
        t_order();
        t_full();
        t_full_pop();
        t_burst();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule